// File: doc/BRIEF.md
# Dual BCD Decade Counter

This block holds two independent decimal digits. Each digit has its own count clock, its own clear input and its own force-to-nine input. It advances through the BCD values 0 to 9 on the falling edge of its own clock. Both controls act at once, with no clock edge needed, and clear wins when both are raised.

Each digit drives a 4-bit parallel output, and bit 0 is the least significant. The most significant bit of a digit falls only when that digit wraps from 9 to 0. Wiring that bit of the low digit to the clock of the high digit therefore gives a two-digit divide-by-100 counter with no extra logic. The digit count is a parameter, and each digit is one instance of the same lane.

Top module: `decade_pair`

## Requirements
- R1: The lanes are independent. A clock, clear or force-to-nine on one lane leaves every other lane's output unchanged. Lane i drives `digitOut[4*i+3:4*i]`.
- R2: When both controls of a lane are low, each falling edge of that lane's clock advances the lane by exactly one count. A rising edge changes nothing.
- R3: The output is BCD, with bit 0 as the least significant bit. In normal use only the values 0 to 9 appear.
- R4: While a lane's clear input is high, its output is 0000. This holds whatever its force-to-nine input and clock are doing, and it takes effect without a clock edge.
- R5: While clear is low and force-to-nine is high, the output is 1001, meaning bit 3 and bit 0 are high. This takes effect without a clock edge. Lowering clear while force-to-nine stays high gives 1001 at once.
- R6: While either control is high, clock edges do not advance the lane. The first falling edge after both controls are released counts up from the held value: 0 goes to 1, and 9 goes to 0.
- R7: From count 9, the next falling edge gives 0. Bit 3 falls on exactly that transition and on no other counting transition.
- R8: Feed lane 0's bit 3 into lane 1's clock. The pair then holds the decimal value of the number of lane-0 falling edges modulo 100, and returns to 00 after 100 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tickN | input | LANES | Per-lane count clock; each lane advances on its falling edge |
| clearIn | input | LANES | Per-lane asynchronous clear to 0, active high, highest priority |
| presetIn | input | LANES | Per-lane asynchronous force to 9, active high |
| digitOut | output | 4*LANES | Per-lane BCD digit, lane i in bits 4*i+3 to 4*i |

## Verification
The bench raises clear and force-to-nine halfway through a count with no clock edge, then checks the output at once. A design that synchronised the controls to the clock would hold the old digit there. It raises both controls together and then lowers only clear. A design with the priority backwards would show 9 while both are high, and a design that ignores the release ordering would stay at 0. It clocks a lane while a control is held and after release, which catches a design that counts through a preset or restarts from 0 instead of from 9. It runs the chained pair for 250 input edges against a two-digit model, which exposes a wrap that leaves bit 3 high, advances on the rising edge, or lets one lane's clock disturb the other.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] TOP_COUNT = DIGIT_W'(9);
  localparam logic [DIGIT_W-1:0] ZERO_COUNT = '0;

  // resolved, mutually exclusive asynchronous force strobes
  typedef struct packed {
    logic forceZero;
    logic forceNine;
  } ctrlStrobes_t;

  // next BCD value; anything at or above nine returns to zero
  function automatic logic [DIGIT_W-1:0] bcdNext(input logic [DIGIT_W-1:0] cur);
    if (cur >= TOP_COUNT) return ZERO_COUNT;
    return cur + DIGIT_W'(1);
  endfunction
endpackage

// File: rtl/decCtrl.sv
module decCtrl
  import dec_pkg::*;
(
  input  logic         clearIn,
  input  logic         presetIn,
  output ctrlStrobes_t strobes
);
  // clear dominates; force-to-nine only when clear is low
  always_comb begin
    strobes.forceZero = clearIn;
    strobes.forceNine = presetIn & ~clearIn;
  end
endmodule

// File: rtl/decDatapath.sv
module decDatapath
  import dec_pkg::*;
(
  input  logic               tickN,
  input  ctrlStrobes_t       strobes,
  output logic [DIGIT_W-1:0] count
);
  logic forceZero;
  logic forceNine;
  logic anyForce;
  logic armed;

  assign forceZero = strobes.forceZero;
  assign forceNine = strobes.forceNine;
  assign anyForce  = forceZero | forceNine;

  always_ff @(negedge tickN or posedge forceZero or posedge forceNine) begin
    if (forceZero)      count <= ZERO_COUNT;
    else if (forceNine) count <= TOP_COUNT;
    else                count <= bcdNext(count);
  end

  // marks that a counting edge has happened since the last force
  always_ff @(negedge tickN or posedge anyForce) begin
    if (anyForce) armed <= 1'b0;
    else          armed <= 1'b1;
  end

  assert_in_range_R3: assert property (@(posedge tickN) count <= TOP_COUNT)
    else $error("digit left BCD range");

  assert_step_one_R2: assert property (@(negedge tickN) disable iff (anyForce)
    (armed && $past(count) != TOP_COUNT) |-> count == $past(count) + DIGIT_W'(1))
    else $error("digit did not step by one");

  assert_wrap_zero_R7: assert property (@(negedge tickN) disable iff (anyForce)
    (armed && $past(count) == TOP_COUNT) |-> count == ZERO_COUNT)
    else $error("digit did not wrap to zero");

  assert_clear_hold_R4: assert property (@(posedge tickN) forceZero |-> count == ZERO_COUNT)
    else $error("clear not holding zero");

  assert_preset_hold_R5: assert property (@(posedge tickN) forceNine |-> count == TOP_COUNT)
    else $error("preset not holding nine");
endmodule

// File: rtl/decade_pair.sv
module decade_pair
  import dec_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic [LANES-1:0]         tickN,
  input  logic [LANES-1:0]         clearIn,
  input  logic [LANES-1:0]         presetIn,
  output logic [LANES*DIGIT_W-1:0] digitOut
);
  localparam int OUT_W = LANES * DIGIT_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ctrlStrobes_t laneStrobes;

    decCtrl u_ctrl (
      .clearIn (clearIn[g]),
      .presetIn(presetIn[g]),
      .strobes (laneStrobes)
    );

    decDatapath u_dp (
      .tickN  (tickN[g]),
      .strobes(laneStrobes),
      .count  (digitOut[g*DIGIT_W +: DIGIT_W])
    );
  end

  initial begin
    if (OUT_W != LANES * 4) $error("digit width must be four bits");
  end
endmodule

// File: tb/sim_decade_pair.sv
module sim_decade_pair;
  logic [1:0] ck;
  logic [1:0] clr;
  logic [1:0] pre;
  logic       chain;
  logic [1:0] tickN;
  logic [7:0] digitOut;
  int         checks;
  int         errors;
  bit         done;
  int         m0;
  int         m1;

  assign tickN[0] = ck[0];
  assign tickN[1] = chain ? digitOut[3] : ck[1];

  decade_pair u0 (
    .tickN   (tickN),
    .clearIn (clr),
    .presetIn(pre),
    .digitOut(digitOut)
  );

  function automatic int nxt(input int v);
    return (v == 9) ? 0 : v + 1;
  endfunction

  task automatic chk(input int lane, input int expv, input string tag);
    int act;
    act = (lane == 0) ? int'(digitOut[3:0]) : int'(digitOut[7:4]);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s lane %0d: actual %0d expected %0d at %0t", tag, lane, act, expv, $time);
    end
  endtask

  // one 125 MHz clock period on the selected lanes; falling edge counts
  task automatic tick(input logic [1:0] mask);
    ck = mask;
    #4;
    ck = 2'b00;
    #4;
  endtask

  task automatic t_reset;
    #1;
    chk(0, 0, "R4 reset");
    chk(1, 0, "R4 reset");
    clr = 2'b00;
    #2;
    m0 = 0;
    m1 = 0;
  endtask

  task automatic t_sequence;
    for (int i = 0; i < 25; i++) begin
      ck = 2'b01;
      #2;
      chk(0, m0, "R2 rising edge holds");
      #2;
      ck = 2'b00;
      m0 = nxt(m0);
      #1;
      chk(0, m0, (m0 == 0) ? "R7 wrap" : "R3 sequence");
      #3;
    end
    for (int i = 0; i < 13; i++) begin
      tick(2'b10);
      m1 = nxt(m1);
      chk(1, m1, "R2 lane1 sequence");
      chk(0, m0, "R1 lane0 untouched");
    end
  endtask

  task automatic t_clearMid;
    while (m0 != 6) begin
      tick(2'b01);
      m0 = nxt(m0);
    end
    clr[0] = 1'b1;
    #1;
    chk(0, 0, "R4 async clear");
    chk(1, m1, "R1 other lane kept");
    #1;
    pre[0] = 1'b1;
    tick(2'b01);
    chk(0, 0, "R4 clear over preset and clock");
    pre[0] = 1'b0;
    tick(2'b01);
    chk(0, 0, "R6 held under clear");
    clr[0] = 1'b0;
    #2;
    tick(2'b01);
    chk(0, 1, "R6 first edge after clear");
    m0 = 1;
  endtask

  task automatic t_presetMid;
    tick(2'b01);
    tick(2'b01);
    m0 = 3;
    chk(0, 3, "R2 before preset");
    pre[0] = 1'b1;
    #1;
    chk(0, 9, "R5 async preset");
    #1;
    tick(2'b01);
    chk(0, 9, "R6 held under preset");
    pre[0] = 1'b0;
    #2;
    tick(2'b01);
    chk(0, 0, "R6 first edge after preset");
    m0 = 0;
  endtask

  task automatic t_both;
    clr[1] = 1'b1;
    pre[1] = 1'b1;
    #1;
    chk(1, 0, "R4 both raised");
    #1;
    clr[1] = 1'b0;
    #1;
    chk(1, 9, "R5 clear dropped under preset");
    #1;
    pre[1] = 1'b0;
    #2;
    tick(2'b10);
    chk(1, 0, "R7 release from nine");
    m1 = 0;
  endtask

  task automatic t_chain;
    clr = 2'b11;
    #2;
    chain = 1'b1;
    #2;
    clr = 2'b00;
    #2;
    m0 = 0;
    m1 = 0;
    chk(1, 0, "R8 chain start");
    for (int i = 1; i <= 250; i++) begin
      tick(2'b01);
      if (m0 == 9) m1 = nxt(m1);
      m0 = nxt(m0);
      chk(0, (i % 100) % 10, "R8 chain low digit");
      chk(1, (i % 100) / 10, "R8 chain high digit");
    end
    chain = 1'b0;
  endtask

  initial begin
    ck     = 2'b00;
    clr    = 2'b11;
    pre    = 2'b00;
    chain  = 1'b0;
    checks = 0;
    errors = 0;
    done   = 1'b0;
    #3;
    t_reset();
    t_sequence();
    t_clearMid();
    t_presetMid();
    t_both();
    t_chain();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule